// File: doc/BRIEF.md
# Checkpoint Codeword-Weight Signature Monitor

The monitor watches the instruction fetch stream of a processor and detects control-flow errors without keeping any table of reference signatures. Every valid fetched word is first compressed to the signature width. It is then folded into a running signature register. Some fetched words carry a tag bit that marks them as checkpoints. For these words the folded signature must be a codeword of a fixed weight: exactly `WEIGHT_M` ones among `SIG_W` bits. Any other value is reported as an error.

At a branch join, the compiler places a correction word on each incoming path. The correction word makes the signature reach the valid weight exactly when the checkpoint at the join target is folded. The monitor treats these words like any other fetched word. A jump that skips or enters a segment at the wrong place leaves a signature of the wrong weight at the next checkpoint. Because the check relies only on this property of the signature, no signature is stored for each block.

The monitor has two outputs. The first is a one-cycle error pulse for each failing checkpoint. The second is a sticky error flag that software clears through a dedicated input.

Top module: `sigweight_monitor`

## Requirements
- R1: After reset, and after any later assertion of `rst_n` low, the signature equals `SEED` (default all zeros), and both `err_pulse` and `err_sticky` are low.
- R2: The signature changes only on cycles where `fetch_vld` is high. When `fetch_vld` is low, the signature holds and `ckpt_tag` is ignored.
- R3: Each word is compressed before folding. `insn_word` is split into `SIG_W`-bit chunks starting from bit 0, and the top chunk is zero-padded. All chunks are then XORed together. With the defaults, the folded value is `insn_word[15:0] ^ insn_word[31:16]`.
- R4: With `FOLD_MODE` = rotate-XOR (default), the fold is `next = {sig[SIG_W-2:0], sig[SIG_W-1]} ^ c`, where `c` is the compressed word.
- R5: With `FOLD_MODE` = add, the fold is `next = (sig + c) mod 2^SIG_W`.
- R6: On a cycle with `fetch_vld` and `ckpt_tag` both high, the checkpoint word is folded in first. The result passes only if its population count equals `WEIGHT_M` exactly. A count that is lower or higher fails.
- R7: A failing checkpoint drives `err_pulse` high for exactly the cycle after its fetch. Consecutive failing checkpoints give consecutive pulses. No pulse occurs without a checkpoint fetch.
- R8: A failing checkpoint sets `err_sticky`, which then stays high until `err_clr` is asserted.
- R9: `err_clr` clears `err_sticky` on the next cycle. If a failing checkpoint arrives in the same cycle, setting takes priority and the flag stays high.
- R10: After every checkpoint, passing or failing, the signature restarts at `SEED` for the next segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_vld | input | 1 | The fetched word on `insn_word` is valid this cycle |
| insn_word | input | INSN_W | Fetched instruction or correction word |
| ckpt_tag | input | 1 | Marks the fetched word as a checkpoint |
| err_clr | input | 1 | Clears the sticky error flag |
| err_pulse | output | 1 | One-cycle pulse per failing checkpoint |
| err_sticky | output | 1 | Latched error flag |

## Verification
The bound checker enforces the following on every cycle:
- the signature holds when there is no fetch, and returns to the seed after each checkpoint;
- error pulses occur only after checkpoint fetches;
- a pulse always coincides with the sticky flag;
- the flag rises only with a pulse, holds until a clear, and drops after a clear that does not coincide with a failing checkpoint.

Other behaviours can only be shown by the bench's scenarios:
- the actual fold arithmetic in both modes;
- the chunk compression, including chunks that cancel each other;
- exact-weight acceptance, with failures both below and above `WEIGHT_M`;
- the effect of an ignored word on a later checkpoint.

// File: rtl/swm_pkg.sv
package swm_pkg;

    // Selects the signature update applied on each fetched word.
    typedef enum logic {
        FOLD_ROTXOR = 1'b0,
        FOLD_ADD    = 1'b1
    } fold_mode_e;

endpackage

// File: rtl/swm_compress.sv
module swm_compress #(
    parameter int INSN_W = 32,
    parameter int SIG_W  = 16
) (
    input  logic [INSN_W-1:0] word_i,
    output logic [SIG_W-1:0]  comp_o
);
    localparam int NCHUNK = (INSN_W + SIG_W - 1) / SIG_W;
    localparam int PAD_W  = NCHUNK * SIG_W;

    logic [PAD_W-1:0] padded;
    logic [SIG_W-1:0] partial [NCHUNK+1];

    assign padded     = PAD_W'(word_i);
    assign partial[0] = '0;

    // XOR the chunks together, starting from the low end of the word.
    for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
        assign partial[g+1] = partial[g] ^ padded[g*SIG_W +: SIG_W];
    end

    assign comp_o = partial[NCHUNK];
endmodule

// File: rtl/swm_fold.sv
module swm_fold
    import swm_pkg::*;
#(
    parameter int         SIG_W     = 16,
    parameter fold_mode_e FOLD_MODE = FOLD_ROTXOR
) (
    input  logic [SIG_W-1:0] sig_i,
    input  logic [SIG_W-1:0] comp_i,
    output logic [SIG_W-1:0] sig_o
);
    if (FOLD_MODE == FOLD_ADD) begin : g_add
        // Modular sum of the signature and the compressed word.
        assign sig_o = sig_i + comp_i;
    end else begin : g_rotxor
        // Rotate left by one so that word order matters, then XOR.
        logic [SIG_W-1:0] rotated;
        assign rotated = {sig_i[SIG_W-2:0], sig_i[SIG_W-1]};
        assign sig_o   = rotated ^ comp_i;
    end
endmodule

// File: rtl/swm_weight_chk.sv
module swm_weight_chk #(
    parameter int SIG_W    = 16,
    parameter int WEIGHT_M = 8
) (
    input  logic [SIG_W-1:0] sig_i,
    output logic             ok_o
);
    localparam int CNT_W = $clog2(SIG_W + 1);

    logic [CNT_W-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < SIG_W; i++) begin
            ones = ones + CNT_W'(sig_i[i]);
        end
    end

    assign ok_o = (ones == CNT_W'(WEIGHT_M));
endmodule

// File: rtl/sigweight_monitor.sv
module sigweight_monitor
    import swm_pkg::*;
#(
    parameter int               INSN_W    = 32,
    parameter int               SIG_W     = 16,
    parameter int               WEIGHT_M  = 8,
    parameter logic [SIG_W-1:0] SEED      = '0,
    parameter fold_mode_e       FOLD_MODE = FOLD_ROTXOR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_vld,
    input  logic [INSN_W-1:0] insn_word,
    input  logic              ckpt_tag,
    input  logic              err_clr,
    output logic              err_pulse,
    output logic              err_sticky
);
    typedef struct packed {
        logic [SIG_W-1:0] sig;
        logic             pulse;
        logic             sticky;
    } mon_state_t;

    localparam mon_state_t RESET_STATE = '{sig: SEED, pulse: 1'b0, sticky: 1'b0};

    mon_state_t       state_d, state_q;
    logic [SIG_W-1:0] comp_word;
    logic [SIG_W-1:0] sig_folded;
    logic             weight_ok;
    logic             ckpt_hit;
    logic [SIG_W-1:0] sig_q;

    swm_compress #(.INSN_W(INSN_W), .SIG_W(SIG_W)) u_compress (
        .word_i (insn_word),
        .comp_o (comp_word)
    );

    swm_fold #(.SIG_W(SIG_W), .FOLD_MODE(FOLD_MODE)) u_fold (
        .sig_i  (state_q.sig),
        .comp_i (comp_word),
        .sig_o  (sig_folded)
    );

    // The weight test sees the signature with the checkpoint word already folded in.
    swm_weight_chk #(.SIG_W(SIG_W), .WEIGHT_M(WEIGHT_M)) u_weight (
        .sig_i (sig_folded),
        .ok_o  (weight_ok)
    );

    assign ckpt_hit = fetch_vld && ckpt_tag;

    always_comb begin
        state_d       = state_q;
        state_d.pulse = 1'b0;
        if (fetch_vld) begin
            state_d.sig = sig_folded;
        end
        if (ckpt_hit) begin
            state_d.sig = SEED;
        end
        if (err_clr) begin
            state_d.sticky = 1'b0;
        end
        if (ckpt_hit && !weight_ok) begin
            state_d.pulse  = 1'b1;
            state_d.sticky = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    assign sig_q      = state_q.sig;
    assign err_pulse  = state_q.pulse;
    assign err_sticky = state_q.sticky;
endmodule

// File: rtl/swm_checker.sv
module swm_checker #(
    parameter int               SIG_W = 16,
    parameter logic [SIG_W-1:0] SEED  = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_vld,
    input logic             ckpt_tag,
    input logic             err_clr,
    input logic             err_pulse,
    input logic             err_sticky,
    input logic [SIG_W-1:0] sig_q
);
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld |=> $stable(sig_q));

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && ckpt_tag) |=> (sig_q == SEED));

    p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_vld && ckpt_tag) |=> !err_pulse);

    p_pulse_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> err_sticky);

    p_flag_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sticky) |-> err_pulse);

    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sticky && !err_clr) |=> err_sticky);

    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(fetch_vld && ckpt_tag)) |=> !err_sticky);
endmodule

bind sigweight_monitor swm_checker #(.SIG_W(SIG_W), .SEED(SEED)) u_swm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_vld  (fetch_vld),
    .ckpt_tag   (ckpt_tag),
    .err_clr    (err_clr),
    .err_pulse  (err_pulse),
    .err_sticky (err_sticky),
    .sig_q      (sig_q)
);

// File: tb/test_sigweight_monitor.sv
`timescale 1ns/1ps
module test_sigweight_monitor;
    import swm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_vld = 1'b0;
    logic [31:0] insn_word = '0;
    logic        ckpt_tag = 1'b0;
    logic        err_clr = 1'b0;
    logic        pulse_rx, sticky_rx, pulse_ad, sticky_ad;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    // Default instance: rotate-XOR fold (R4).
    sigweight_monitor i_sigweight_monitor (
        .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .insn_word(insn_word),
        .ckpt_tag(ckpt_tag), .err_clr(err_clr),
        .err_pulse(pulse_rx), .err_sticky(sticky_rx)
    );

    // Second instance: add fold (R5).
    sigweight_monitor #(.FOLD_MODE(FOLD_ADD)) i_sigweight_monitor_add (
        .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .insn_word(insn_word),
        .ckpt_tag(ckpt_tag), .err_clr(err_clr),
        .err_pulse(pulse_ad), .err_sticky(sticky_ad)
    );

    typedef struct packed {
        logic        vld;
        logic        tag;
        logic        clr;
        logic [31:0] insn;
        logic        p_rx;
        logic        p_ad;
        logic        s_rx;
        logic        s_ad;
    } vec_t;

    // Expected flags: pulse and sticky for each instance, sampled one cycle after the fetch.
    localparam vec_t VECS [15] = '{
        '{1'b1, 1'b1, 1'b0, 32'h0000_00FF, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 weight 8 passes
        '{1'b1, 1'b1, 1'b0, 32'h0000_0001, 1'b1, 1'b1, 1'b1, 1'b1}, // R6 weight 1 fails, R7 R8
        '{1'b0, 1'b1, 1'b0, 32'h0000_0001, 1'b0, 1'b0, 1'b1, 1'b1}, // R2 tag ignored without fetch
        '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 clear
        '{1'b1, 1'b0, 1'b0, 32'h0000_000F, 1'b0, 1'b0, 1'b0, 1'b0}, // fold 0x000F
        '{1'b1, 1'b1, 1'b0, 32'h0000_00F0, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 0x00EE fails, R5 0x00FF passes
        '{1'b1, 1'b1, 1'b0, 32'h0F00_00F0, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 halves give 0x0FF0, R10
        '{1'b1, 1'b1, 1'b0, 32'h00FF_00FF, 1'b1, 1'b1, 1'b1, 1'b1}, // R3 halves cancel to zero
        '{1'b1, 1'b0, 1'b0, 32'h0000_0003, 1'b0, 1'b0, 1'b1, 1'b1}, // fold 0x0003
        '{1'b0, 1'b0, 1'b0, 32'h0000_0001, 1'b0, 1'b0, 1'b1, 1'b1}, // R2 word ignored
        '{1'b1, 1'b1, 1'b0, 32'h0000_3F00, 1'b0, 1'b0, 1'b1, 1'b1}, // R2 passes only if ignored word left sig alone
        '{1'b1, 1'b1, 1'b1, 32'h0000_0001, 1'b1, 1'b1, 1'b1, 1'b1}, // R9 set beats clear
        '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 clear
        '{1'b1, 1'b1, 1'b0, 32'h0000_FF00, 1'b0, 1'b0, 1'b0, 1'b0}, // R10 restart after a failing checkpoint
        '{1'b1, 1'b1, 1'b0, 32'h0000_01FF, 1'b1, 1'b1, 1'b1, 1'b1}  // R6 weight 9 fails
    };

    task automatic check(input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    // Inputs are applied at a falling edge; outputs are sampled at the next falling edge.
    task automatic step(input logic v, input logic t, input logic c, input logic [31:0] w);
        fetch_vld = v; ckpt_tag = t; err_clr = c; insn_word = w;
        @(posedge clk);
        @(negedge clk);
        fetch_vld = 1'b0; ckpt_tag = 1'b0; err_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset err_pulse rotxor", pulse_rx, 1'b0);
        check("R1 reset err_sticky rotxor", sticky_rx, 1'b0);
        check("R1 reset err_pulse add", pulse_ad, 1'b0);
        check("R1 reset err_sticky add", sticky_ad, 1'b0);
        rst_n = 1'b1;

        foreach (VECS[i]) begin
            step(VECS[i].vld, VECS[i].tag, VECS[i].clr, VECS[i].insn);
            check($sformatf("R7 err_pulse rotxor row %0d", i), pulse_rx, VECS[i].p_rx);
            check($sformatf("R7 err_pulse add row %0d", i), pulse_ad, VECS[i].p_ad);
            check($sformatf("R8 err_sticky rotxor row %0d", i), sticky_rx, VECS[i].s_rx);
            check($sformatf("R8 err_sticky add row %0d", i), sticky_ad, VECS[i].s_ad);
        end

        // R8: the flag persists over idle cycles and the pulse does not.
        repeat (20) step(1'b0, 1'b0, 1'b0, 32'h0);
        check("R8 sticky held rotxor", sticky_rx, 1'b1);
        check("R8 sticky held add", sticky_ad, 1'b1);
        check("R7 no pulse while idle", pulse_rx, 1'b0);

        // R7: back-to-back failing checkpoints give back-to-back pulses.
        step(1'b0, 1'b0, 1'b1, 32'h0);
        step(1'b1, 1'b1, 1'b0, 32'h0000_0007);
        check("R7 first of two pulses", pulse_rx, 1'b1);
        step(1'b1, 1'b1, 1'b0, 32'h0000_0007);
        check("R7 second of two pulses", pulse_rx, 1'b1);
        check("R7 second of two pulses add", pulse_ad, 1'b1);
        step(1'b0, 1'b0, 1'b0, 32'h0);
        check("R7 pulse drops", pulse_rx, 1'b0);

        // R1: a reset in mid-segment discards the partial signature and the flag.
        step(1'b1, 1'b0, 1'b0, 32'h0000_000F);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid reset sticky", sticky_rx, 1'b0);
        check("R1 mid reset pulse", pulse_rx, 1'b0);
        rst_n = 1'b1;
        step(1'b1, 1'b1, 1'b0, 32'h0000_00FF);
        check("R1 seed restored rotxor", pulse_rx, 1'b0);
        check("R1 seed restored add", pulse_ad, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule